// File: doc/BRIEF.md
# Parity-Checked Word Memory

This block is a single-port data memory that keeps a 16-bit word together with one parity bit in each 17-bit location. Each write computes the parity bit. Each read checks the whole stored word. A read that fails the check raises a one-cycle error pulse in the same cycle as the read data. The same failure also sets a sticky error flag and latches the failing address, so that a logging queue or host can record where the fault occurred.

A host issues a request with `reqValid`, choosing write or read with `reqWrite`. Read data is registered and appears one cycle after the request. A test input stores the inverted parity bit on a write, which lets software or a bench plant a known-bad word and confirm that the checker catches it.

Top module: `parity_word_ram`

## Requirements
- R1: A read request returns, one clock after the request edge, the data last written to that address on `readData`, with `readValid` high for exactly that one cycle.
- R2: Parity is odd: a normal write stores a parity bit chosen so that the 17 stored bits hold an odd number of ones. Reading any normally written word, including data 0x0000 and 0xFFFF, never raises `parityErr`.
- R3: A write with `injectParity` high stores the inverted parity bit. A later read of that word raises `parityErr`. This includes the all-zero stored word produced by writing 0x0000 with injection.
- R4: `parityErr` is a single-cycle pulse. It is only ever high in a cycle where `readValid` is high.
- R5: `errAddr` takes the address of a failing read in the cycle its `parityErr` pulse is shown. It keeps that value through later good reads and writes until the next failing read. It resets to 0.
- R6: `stickyErr` goes high with the first `parityErr` pulse. It stays high until a cycle in which `clearSticky` is sampled high.
- R7: If `clearSticky` is sampled on the same edge as a failing read, the new error wins and `stickyErr` stays set. A clear with no error on that edge drops the flag on the next cycle.
- R8: Write requests and idle cycles never raise `readValid` or `parityErr`, and `readData` holds the last read value through them.
- R9: After reset, `readValid`, `parityErr` and `stickyErr` are low and `errAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe for this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (6) | Word address |
| writeData | input | DATA_W (16) | Data to store |
| injectParity | input | 1 | On a write, store inverted parity |
| clearSticky | input | 1 | Clears the sticky error flag |
| readData | output | DATA_W (16) | Registered read data |
| readValid | output | 1 | Read data valid pulse |
| parityErr | output | 1 | Parity failure pulse, aligned with readValid |
| errAddr | output | ADDR_W (6) | Address of the latest failing read |
| stickyErr | output | 1 | Sticky parity error flag |

## Verification
A failing read and a host clear of the sticky flag can land on the same clock edge. The bench provokes this by issuing a read of a word planted with inverted parity while `clearSticky` is held high in that same request cycle. It judges the result by sampling `stickyErr` on the following falling edge and expecting it still set. It then applies a lone clear and expects the flag to drop, which shows that the earlier survival came from the new error and not from an ignored clear.

// File: rtl/ppram_pkg.sv
package ppram_pkg;

  // Strobes from control to datapath for the current request cycle.
  typedef struct packed {
    logic wrEn;     // store word at the request address
    logic rdEn;     // fetch and check word at the request address
    logic flipPar;  // store the inverted parity bit (test use)
  } ramStrobes_t;

endpackage

// File: rtl/ppram_datapath.sv
module ppram_datapath
  import ppram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] writeData,
  output logic [DATA_W-1:0] readData,
  output logic              readValid,
  output logic              rdMismatch
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] store [DEPTH];
  logic              genPar;
  logic [WORD_W-1:0] fetched;

  // Odd parity: the parity bit makes the total count of ones odd.
  always_comb begin
    genPar = ~(^writeData);
    if (strobes.flipPar) genPar = ~genPar;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[addr] <= {genPar, writeData};
  end

  assign fetched    = store[addr];
  assign rdMismatch = strobes.rdEn & ~(^fetched);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData  <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= strobes.rdEn;
      if (strobes.rdEn) readData <= fetched[DATA_W-1:0];
    end
  end

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> readValid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> (!readValid && $stable(readData)));

endmodule

// File: rtl/ppram_ctrl.sv
module ppram_ctrl
  import ppram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              injectParity,
  input  logic              clearSticky,
  input  logic              rdMismatch,
  output ramStrobes_t       strobes,
  output logic              parityErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic              stickyErr
);

  always_comb begin
    strobes.wrEn    = reqValid & reqWrite;
    strobes.rdEn    = reqValid & ~reqWrite;
    strobes.flipPar = reqValid & reqWrite & injectParity;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      errAddr   <= '0;
      stickyErr <= 1'b0;
    end else begin
      parityErr <= rdMismatch;
      if (rdMismatch) errAddr <= reqAddr;
      // A new failure outranks a clear on the same edge.
      stickyErr <= rdMismatch | (stickyErr & ~clearSticky);
    end
  end

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stickyErr && !clearSticky) |=> stickyErr);

  assert_new_err_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdMismatch |=> (stickyErr && parityErr));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearSticky && !rdMismatch) |=> !stickyErr);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !parityErr |-> $stable(errAddr));

endmodule

// File: rtl/parity_word_ram.sv
module parity_word_ram
  import ppram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] writeData,
  input  logic              injectParity,
  input  logic              clearSticky,
  output logic [DATA_W-1:0] readData,
  output logic              readValid,
  output logic              parityErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic              stickyErr
);

  ramStrobes_t strobes;
  logic        rdMismatch;

  ppram_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .injectParity(injectParity), .clearSticky(clearSticky),
    .rdMismatch(rdMismatch), .strobes(strobes), .parityErr(parityErr),
    .errAddr(errAddr), .stickyErr(stickyErr)
  );

  ppram_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(reqAddr),
    .writeData(writeData), .readData(readData), .readValid(readValid),
    .rdMismatch(rdMismatch)
  );

  assert_err_with_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> readValid);

  assert_err_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr || readValid);

  assert_err_sets_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> stickyErr);

endmodule

// File: tb/parity_word_ram_test.sv
`timescale 1ns/100ps
module parity_word_ram_test;

  localparam int DW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, injectParity = 1'b0, clearSticky = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] writeData = '0;
  logic [DW-1:0] readData;
  logic          readValid, parityErr, stickyErr;
  logic [AW-1:0] errAddr;

  always #2.5 clk = ~clk;

  parity_word_ram #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .writeData(writeData), .injectParity(injectParity),
    .clearSticky(clearSticky), .readData(readData), .readValid(readValid),
    .parityErr(parityErr), .errAddr(errAddr), .stickyErr(stickyErr)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          bad;
    logic [AW-1:0] addr;
  } expItem_t;

  expItem_t      expQ[$];
  logic [DW-1:0] modelData [1<<AW];
  logic          modelBad  [1<<AW];
  logic [DW-1:0] lastRead = '0;
  int            applied = 0;
  int            miscompares = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic inj);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; writeData = d; injectParity = inj;
    modelData[a] = d; modelBad[a] = inj;
    @(posedge clk); #1;
    reqValid = 1'b0; injectParity = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic clr);
    expItem_t it;
    it.data = modelData[a]; it.bad = modelBad[a]; it.addr = a;
    expQ.push_back(it);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; clearSticky = clr;
    @(posedge clk); #1;
    reqValid = 1'b0; clearSticky = 1'b0;
  endtask

  task automatic pulseClear();
    clearSticky = 1'b1;
    @(posedge clk); #1;
    clearSticky = 1'b0;
  endtask

  // Monitor: pops expected items as read results appear.
  always @(negedge clk) begin
    if (rstN) begin
      if (parityErr && !readValid) check(1'b0, "R4 err without valid", parityErr, 0);
      if (readValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected readValid", readValid, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(readData == it.data, "R1 read data", readData, it.data);
          check(parityErr == it.bad, it.bad ? "R3 parity flag" : "R2 parity flag", parityErr, it.bad);
          if (it.bad) check(errAddr == it.addr, "R5 errAddr on fail", errAddr, it.addr);
          lastRead = it.data;
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!readValid, "R9 readValid reset", readValid, 0);
    check(!parityErr, "R9 parityErr reset", parityErr, 0);
    check(!stickyErr, "R9 stickyErr reset", stickyErr, 0);
    check(errAddr == 0, "R9 errAddr reset", errAddr, 0);
    @(posedge clk); #1;

    // R2: normal writes of varied patterns, including all-zero and all-one data.
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] d;
      d = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (DW'(i) * 16'h1357) ^ 16'hA5C3;
      doWrite(AW'(i), d, 1'b0);
    end
    for (int i = 15; i >= 0; i--) doRead(AW'(i), 1'b0);
    doRead(6'd1, 1'b0); doRead(6'd1, 1'b0);
    @(negedge clk);
    check(!stickyErr, "R2 no sticky after good reads", stickyErr, 0);

    // R8: writes leave readData and readValid untouched.
    doWrite(6'd30, 16'h1234, 1'b0);
    doWrite(6'd31, 16'h4321, 1'b0);
    @(negedge clk);
    check(readData == lastRead, "R8 readData held over writes", readData, lastRead);

    // R3: planted errors, including an all-zero stored word.
    doWrite(6'd20, 16'h0000, 1'b1);
    doWrite(6'd21, 16'h8001, 1'b1);
    doRead(6'd20, 1'b0);
    @(negedge clk);
    check(stickyErr, "R6 sticky set by failure", stickyErr, 1);
    check(errAddr == 20, "R5 errAddr latched", errAddr, 20);
    doRead(6'd3, 1'b0);
    doWrite(6'd4, 16'h0F0F, 1'b0);
    @(negedge clk);
    check(errAddr == 20, "R5 errAddr held over good ops", errAddr, 20);
    check(stickyErr, "R6 sticky held", stickyErr, 1);
    doRead(6'd21, 1'b0);
    @(negedge clk);
    check(errAddr == 21, "R5 errAddr updated", errAddr, 21);

    // R6/R7: plain clear, then clear colliding with a new failure.
    pulseClear();
    @(negedge clk);
    check(!stickyErr, "R7 lone clear drops flag", stickyErr, 0);
    doRead(6'd21, 1'b1);
    @(negedge clk);
    check(stickyErr, "R7 new error beats clear", stickyErr, 1);
    pulseClear();
    @(negedge clk);
    check(!stickyErr, "R6 clear after collision", stickyErr, 0);

    // R2: overwrite a planted word normally and it reads clean.
    doWrite(6'd20, 16'h0000, 1'b0);
    doRead(6'd20, 1'b0);
    doRead(6'd30, 1'b0);
    @(negedge clk);
    check(!stickyErr, "R2 repaired word clean", stickyErr, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all reads answered", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule